// File: doc/BRIEF.md
# Timekeeper Register File with Shadow Copies

This block holds the time, calendar, alarm, watchdog and command registers of a real-time clock, plus a bank of general-purpose bytes, behind a simple select/read/write register port. Every clock, calendar, alarm and watchdog register exists twice. A working copy counts. A host-visible copy is what the read port returns. A once-per-second tick advances the working copy in BCD, with carries through seconds, minutes, hours, weekday, date, month and year. Month lengths and leap years are taken into account.

Once a working value changes, every host-visible copy is reloaded from the working copies in a single clock. That reload waits while the host is reading the timekeeping area, so a read never returns a mix of old and new fields. Host writes to a timekeeping register load the working copy, so counting resumes from the written value. The command register has a single copy. Both host writes and internal event inputs modify it. Offsets 0x0E to 0x3F are plain storage bytes.

Top module: `tkreg_file`

## Requirements
- R1: After reset, offsets 0x06 (weekday), 0x08 (date) and 0x09 (month) read 0x01, and every other offset from 0x00 to 0x3F reads 0x00.
- R2: The read port is combinational. Offsets 0x00-0x0A, 0x0C and 0x0D return the host-visible copy, offset 0x0B returns the command register, and offsets 0x0E-0x3F return the storage byte at that offset.
- R3: Each tick advances the seconds at offset 0x01 in BCD from 00 to 59 and then wraps to 00 with a carry. The minutes at offset 0x02 follow the same 00-59 rule, and the hours at offset 0x04 count 00-23.
- R4: An hour carry advances the weekday at offset 0x06 (01-07, then 01) and the date at offset 0x08. After the last day of the month (31; 30 for months 04, 06, 09 and 11; 28 for month 02, or 29 when the year is a multiple of 4), the date returns to 01 and the month at offset 0x09 advances. Month 12 wraps to 01 and advances the year at offset 0x0A, and year 99 wraps to 00.
- R5: Each tick clears the sub-second byte at offset 0x00 to 00.
- R6: A host write to offsets 0x00-0x0A, 0x0C or 0x0D loads the working copy. The read port shows the new value one clock after the write edge, not before it, and counting continues from that value.
- R7: When a host write and a tick fall in the same cycle, the written register takes the write data. Every other field advances as if the tick had acted on the old values.
- R8: All host-visible copies are reloaded together from the working copies in the clock after any working value changes. The reload is held off for as long as a read at an offset 0x00-0x0D is active, and the host-visible copies never change at any other time.
- R9: A host write to offset 0x0B stores the data. Every bit set on the event input is set in the command register on that clock, and it takes priority over the write data.
- R10: The storage bytes at 0x0E-0x3F keep what was written and are not affected by ticks.
- R11: The alarm bytes (0x03, 0x05, 0x07) and watchdog bytes (0x0C, 0x0D) change only through host writes, never through ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| sec_tick_i | input | 1 | One-cycle pulse, once per second |
| evt_set_i | input | 8 | Command-register bits set by internal events |
| reg_rd_i | input | 1 | Read strobe (holds off the reload on offsets 0x00-0x0D) |
| reg_wr_i | input | 1 | Write strobe |
| reg_addr_i | input | 6 | Register offset |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data for reg_addr_i |

## Verification
A wrong carry or month-length decision in the working copy reaches the read port one clock after the tick that produces it. The bench therefore sweeps month ends across leap and common years, as well as long runs of consecutive seconds, and compares each one with an arithmetic model. A broken reload gate shows up as a value that changes while a read is held, or that stays old one clock after it should have moved. Both are probed at the exact cycle. A lost event bit or a tick leaking into the alarm or storage bytes appears on the next read of that offset.

// File: rtl/tk_pkg.sv
package tk_pkg;

    localparam int DW   = 8;
    localparam int NREG = 14;

    localparam int OFS_FRAC = 0;
    localparam int OFS_SEC  = 1;
    localparam int OFS_MIN  = 2;
    localparam int OFS_AMIN = 3;
    localparam int OFS_HOUR = 4;
    localparam int OFS_AHR  = 5;
    localparam int OFS_DOW  = 6;
    localparam int OFS_ADOW = 7;
    localparam int OFS_DATE = 8;
    localparam int OFS_MON  = 9;
    localparam int OFS_YEAR = 10;
    localparam int OFS_CMD  = 11;
    localparam int OFS_WDLO = 12;
    localparam int OFS_WDHI = 13;

    typedef logic [DW-1:0] byte_t;
    typedef logic [NREG-1:0][DW-1:0] bank_t;

    typedef struct packed {
        byte_t sec;
        byte_t min;
        byte_t hour;
        byte_t dow;
        byte_t date;
        byte_t mon;
        byte_t year;
    } clk_t;

    // BCD plus one on a two-digit value
    function automatic byte_t bcd_inc(input byte_t v);
        byte_t r;
        if (v[3:0] >= 4'd9) r = {v[7:4] + 4'd1, 4'd0};
        else                r = {v[7:4], v[3:0] + 4'd1};
        return r;
    endfunction

    function automatic logic [6:0] bcd_to_bin(input byte_t v);
        return ({3'd0, v[7:4]} * 7'd10) + {3'd0, v[3:0]};
    endfunction

    // last date of a month, returned in BCD
    function automatic byte_t month_last(input byte_t mon, input byte_t year);
        logic [6:0] m;
        logic [6:0] y;
        byte_t r;
        m = bcd_to_bin(mon);
        y = bcd_to_bin(year);
        case (m)
            7'd2:                     r = (y[1:0] == 2'd0) ? 8'h29 : 8'h28;
            7'd4, 7'd6, 7'd9, 7'd11:  r = 8'h30;
            default:                  r = 8'h31;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/tk_time_step.sv
module tk_time_step
    import tk_pkg::*;
(
    input  clk_t cur_i,
    output clk_t nxt_o
);
    logic  c_sec, c_min, c_day, c_date, c_mon;
    logic  last_day;
    byte_t dim;

    always_comb begin
        nxt_o    = cur_i;
        dim      = month_last(cur_i.mon, cur_i.year);
        last_day = (cur_i.date >= dim);

        c_sec  = (cur_i.sec  >= 8'h59);
        c_min  = c_sec && (cur_i.min  >= 8'h59);
        c_day  = c_min && (cur_i.hour >= 8'h23);
        c_date = c_day && last_day;
        c_mon  = c_date && (cur_i.mon >= 8'h12);

        nxt_o.sec = c_sec ? 8'h00 : bcd_inc(cur_i.sec);
        if (c_sec)
            nxt_o.min = (cur_i.min >= 8'h59) ? 8'h00 : bcd_inc(cur_i.min);
        if (c_min)
            nxt_o.hour = (cur_i.hour >= 8'h23) ? 8'h00 : bcd_inc(cur_i.hour);
        if (c_day) begin
            nxt_o.dow  = (cur_i.dow >= 8'h07) ? 8'h01 : bcd_inc(cur_i.dow);
            nxt_o.date = last_day ? 8'h01 : bcd_inc(cur_i.date);
        end
        if (c_date)
            nxt_o.mon = (cur_i.mon >= 8'h12) ? 8'h01 : bcd_inc(cur_i.mon);
        if (c_mon)
            nxt_o.year = (cur_i.year >= 8'h99) ? 8'h00 : bcd_inc(cur_i.year);
    end
endmodule

// File: rtl/tk_user_bytes.sv
module tk_user_bytes
    import tk_pkg::*;
#(
    parameter int AW    = 6,
    parameter int BASE  = 14,
    parameter int DEPTH = 50
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          wr_i,
    input  logic [AW-1:0] addr_i,
    input  byte_t         wdata_i,
    output logic          hit_o,
    output byte_t         rdata_o
);
    localparam int IW = $clog2(DEPTH);

    typedef logic [DEPTH-1:0][DW-1:0] mem_t;

    mem_t          mem_d, mem_q;
    logic [AW:0]   rel;
    logic [IW-1:0] idx;

    always_comb begin
        rel     = {1'b0, addr_i} - (AW+1)'(BASE);
        idx     = rel[IW-1:0];
        hit_o   = ({1'b0, addr_i} >= (AW+1)'(BASE)) &&
                  ({1'b0, addr_i} <  (AW+1)'(BASE + DEPTH));
        mem_d   = mem_q;
        rdata_o = '0;
        if (hit_o) begin
            rdata_o = mem_q[idx];
            if (wr_i) mem_d[idx] = wdata_i;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) mem_q <= '0;
        else         mem_q <= mem_d;
    end
endmodule

// File: rtl/tkreg_file.sv
module tkreg_file
    import tk_pkg::*;
#(
    parameter int AW    = 6,
    parameter int NUSER = 50
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          sec_tick_i,
    input  logic [DW-1:0] evt_set_i,
    input  logic          reg_rd_i,
    input  logic          reg_wr_i,
    input  logic [AW-1:0] reg_addr_i,
    input  logic [DW-1:0] reg_wdata_i,
    output logic [DW-1:0] reg_rdata_o
);
    localparam int USER_BASE = NREG;
    localparam int IDXW      = $clog2(NREG);

    typedef struct packed {
        bank_t work;
        bank_t shown;
        byte_t cmd;
        logic  pend;
    } st_t;

    st_t st_d, st_q;

    clk_t cur_t, nxt_t;
    logic time_hit, shadow_wr, cmd_wr, rd_block;
    logic [IDXW-1:0] ridx;
    logic  ub_hit;
    byte_t ub_rdata;

    // signals observed by the bound checker
    bank_t work_bank, shown_bank;
    byte_t cmd_reg;
    logic  xfer_pend;

    assign work_bank  = st_q.work;
    assign shown_bank = st_q.shown;
    assign cmd_reg    = st_q.cmd;
    assign xfer_pend  = st_q.pend;

    assign cur_t = '{sec:  st_q.work[OFS_SEC],  min:  st_q.work[OFS_MIN],
                     hour: st_q.work[OFS_HOUR], dow:  st_q.work[OFS_DOW],
                     date: st_q.work[OFS_DATE], mon:  st_q.work[OFS_MON],
                     year: st_q.work[OFS_YEAR]};

    tk_time_step step_i (
        .cur_i (cur_t),
        .nxt_o (nxt_t)
    );

    tk_user_bytes #(
        .AW    (AW),
        .BASE  (USER_BASE),
        .DEPTH (NUSER)
    ) ub_i (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .wr_i    (reg_wr_i),
        .addr_i  (reg_addr_i),
        .wdata_i (reg_wdata_i),
        .hit_o   (ub_hit),
        .rdata_o (ub_rdata)
    );

    always_comb begin
        st_d      = st_q;
        time_hit  = (reg_addr_i < AW'(NREG));
        ridx      = reg_addr_i[IDXW-1:0];
        cmd_wr    = reg_wr_i && time_hit && (ridx == IDXW'(OFS_CMD));
        shadow_wr = reg_wr_i && time_hit && (ridx != IDXW'(OFS_CMD));
        rd_block  = reg_rd_i && time_hit;

        // reload of every host-visible copy in one clock
        if (st_q.pend && !rd_block) begin
            st_d.shown = st_q.work;
            st_d.pend  = 1'b0;
        end

        if (sec_tick_i) begin
            st_d.work[OFS_FRAC] = 8'h00;
            st_d.work[OFS_SEC]  = nxt_t.sec;
            st_d.work[OFS_MIN]  = nxt_t.min;
            st_d.work[OFS_HOUR] = nxt_t.hour;
            st_d.work[OFS_DOW]  = nxt_t.dow;
            st_d.work[OFS_DATE] = nxt_t.date;
            st_d.work[OFS_MON]  = nxt_t.mon;
            st_d.work[OFS_YEAR] = nxt_t.year;
            st_d.pend           = 1'b1;
        end

        if (shadow_wr) begin
            st_d.work[ridx] = reg_wdata_i;
            st_d.pend       = 1'b1;
        end

        if (cmd_wr) st_d.cmd = reg_wdata_i;
        st_d.cmd = st_d.cmd | evt_set_i;

        // read mux
        if (time_hit) begin
            if (ridx == IDXW'(OFS_CMD)) reg_rdata_o = st_q.cmd;
            else                         reg_rdata_o = st_q.shown[ridx];
        end else if (ub_hit) begin
            reg_rdata_o = ub_rdata;
        end else begin
            reg_rdata_o = '0;
        end
    end

    function automatic bank_t reset_bank();
        bank_t b;
        b           = '0;
        b[OFS_DOW]  = 8'h01;
        b[OFS_DATE] = 8'h01;
        b[OFS_MON]  = 8'h01;
        return b;
    endfunction

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q.work  <= reset_bank();
            st_q.shown <= reset_bank();
            st_q.cmd   <= '0;
            st_q.pend  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/tkreg_file_chk.sv
module tkreg_file_chk
    import tk_pkg::*;
#(
    parameter int AW = 6
) (
    input logic          clk_i,
    input logic          rst_ni,
    input logic          sec_tick_i,
    input logic [DW-1:0] evt_set_i,
    input logic          reg_rd_i,
    input logic          reg_wr_i,
    input logic [AW-1:0] reg_addr_i,
    input logic [DW-1:0] reg_rdata_o,
    input bank_t         work_bank,
    input bank_t         shown_bank,
    input byte_t         cmd_reg,
    input logic          xfer_pend
);
    logic valid_q;
    logic blk, tick_nowr0, alarm_wr;

    always_ff @(posedge clk_i) begin
        if (!rst_ni) valid_q <= 1'b0;
        else         valid_q <= 1'b1;
    end

    assign blk        = reg_rd_i && (reg_addr_i < AW'(NREG));
    assign tick_nowr0 = sec_tick_i && !(reg_wr_i && reg_addr_i == AW'(OFS_FRAC));
    assign alarm_wr   = reg_wr_i && (reg_addr_i == AW'(OFS_AMIN) ||
                                     reg_addr_i == AW'(OFS_AHR)  ||
                                     reg_addr_i == AW'(OFS_ADOW) ||
                                     reg_addr_i == AW'(OFS_WDLO) ||
                                     reg_addr_i == AW'(OFS_WDHI));

    p_read_steady_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (valid_q && $past(blk) && blk && reg_addr_i == $past(reg_addr_i) &&
         reg_addr_i != AW'(OFS_CMD)) |-> $stable(reg_rdata_o));

    p_shown_only_on_xfer_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (valid_q && !$past(xfer_pend && !blk)) |-> $stable(shown_bank));

    p_xfer_copies_all_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (valid_q && $past(xfer_pend && !blk)) |-> shown_bank == $past(work_bank));

    p_frac_cleared_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (valid_q && $past(tick_nowr0)) |-> work_bank[OFS_FRAC] == 8'h00);

    p_event_sets_cmd_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        valid_q |-> (cmd_reg & $past(evt_set_i)) == $past(evt_set_i));

    p_alarm_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (valid_q && !$past(alarm_wr)) |->
            (work_bank[OFS_AMIN] == $past(work_bank[OFS_AMIN]) &&
             work_bank[OFS_AHR]  == $past(work_bank[OFS_AHR])  &&
             work_bank[OFS_ADOW] == $past(work_bank[OFS_ADOW]) &&
             work_bank[OFS_WDLO] == $past(work_bank[OFS_WDLO]) &&
             work_bank[OFS_WDHI] == $past(work_bank[OFS_WDHI])));
endmodule

bind tkreg_file tkreg_file_chk #(.AW(AW)) chk_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sec_tick_i  (sec_tick_i),
    .evt_set_i   (evt_set_i),
    .reg_rd_i    (reg_rd_i),
    .reg_wr_i    (reg_wr_i),
    .reg_addr_i  (reg_addr_i),
    .reg_rdata_o (reg_rdata_o),
    .work_bank   (work_bank),
    .shown_bank  (shown_bank),
    .cmd_reg     (cmd_reg),
    .xfer_pend   (xfer_pend)
);

// File: tb/tkreg_file_tb_top.sv
`timescale 1ns/1ps
module tkreg_file_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic [7:0] evt = '0;
    logic       rd = 1'b0;
    logic       wr = 1'b0;
    logic [5:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;

    int checks = 0;
    int errors = 0;

    // model state, binary
    int ms, mm, mh, mdw, mdt, mmo, my;

    always #2.5 clk = ~clk;

    tkreg_file dut_i (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .sec_tick_i  (tick),
        .evt_set_i   (evt),
        .reg_rd_i    (rd),
        .reg_wr_i    (wr),
        .reg_addr_i  (addr),
        .reg_wdata_i (wdata),
        .reg_rdata_o (rdata)
    );

    function automatic int to_bcd(int v);
        return ((v / 10) << 4) | (v % 10);
    endfunction

    function automatic int dim(int mo, int y);
        if (mo == 2) return (y % 4 == 0) ? 29 : 28;
        if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
        return 31;
    endfunction

    task automatic chk(string req, int got, int exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic rd_at(int a, output int v);
        @(negedge clk);
        rd = 1'b1; addr = 6'(a);
        #0.5 v = int'(rdata);
        #0.5 rd = 1'b0;
    endtask

    task automatic wr_at(int a, int d);
        @(negedge clk);
        wr = 1'b1; addr = 6'(a); wdata = 8'(d);
        @(negedge clk);
        wr = 1'b0;
        @(negedge clk);
    endtask

    task automatic tick_once();
        @(negedge clk);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        @(negedge clk);
    endtask

    task automatic model_step();
        ms++;
        if (ms == 60) begin
            ms = 0; mm++;
            if (mm == 60) begin
                mm = 0; mh++;
                if (mh == 24) begin
                    mh = 0;
                    mdw = (mdw == 7) ? 1 : mdw + 1;
                    mdt++;
                    if (mdt > dim(mmo, my)) begin
                        mdt = 1; mmo++;
                        if (mmo == 13) begin mmo = 1; my = (my + 1) % 100; end
                    end
                end
            end
        end
    endtask

    task automatic load_time(int s, int m, int h, int dw, int dt, int mo, int y);
        ms = s; mm = m; mh = h; mdw = dw; mdt = dt; mmo = mo; my = y;
        wr_at(1, to_bcd(s));  wr_at(2, to_bcd(m));  wr_at(4, to_bcd(h));
        wr_at(6, to_bcd(dw)); wr_at(8, to_bcd(dt)); wr_at(9, to_bcd(mo));
        wr_at(10, to_bcd(y));
    endtask

    task automatic cmp_time(string req);
        int v;
        rd_at(1, v);  chk({req, " sec"},   v, to_bcd(ms));
        rd_at(2, v);  chk({req, " min"},   v, to_bcd(mm));
        rd_at(4, v);  chk({req, " hour"},  v, to_bcd(mh));
        rd_at(6, v);  chk({req, " dow"},   v, to_bcd(mdw));
        rd_at(8, v);  chk({req, " date"},  v, to_bcd(mdt));
        rd_at(9, v);  chk({req, " month"}, v, to_bcd(mmo));
        rd_at(10, v); chk({req, " year"},  v, to_bcd(my));
    endtask

    initial begin
        #1000000;
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int v;
        int yrs[4] = '{23, 24, 0, 99};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset values over the whole offset space
        for (int a = 0; a < 64; a++) begin
            rd_at(a, v);
            chk("R1 reset", v, (a == 6 || a == 8 || a == 9) ? 1 : 0);
        end

        // R10 storage bytes
        for (int a = 14; a < 64; a++) wr_at(a, (a * 7 + 3) & 8'hff);
        tick_once();
        for (int a = 14; a < 64; a++) begin
            rd_at(a, v);
            chk("R10 storage byte", v, (a * 7 + 3) & 8'hff);
        end

        // R11 / R2 alarm and watchdog bytes survive ticks
        wr_at(3, 8'h45); wr_at(5, 8'h12); wr_at(7, 8'h03);
        wr_at(12, 8'h77); wr_at(13, 8'h19);
        repeat (3) tick_once();
        rd_at(3, v);  chk("R11 alarm min", v, 8'h45);
        rd_at(5, v);  chk("R11 alarm hour", v, 8'h12);
        rd_at(7, v);  chk("R11 alarm day", v, 8'h03);
        rd_at(12, v); chk("R11 watchdog lo", v, 8'h77);
        rd_at(13, v); chk("R2 watchdog hi", v, 8'h19);

        // R9 command register
        wr_at(11, 8'h12);
        rd_at(11, v); chk("R9 cmd write", v, 8'h12);
        @(negedge clk); evt = 8'h81; @(negedge clk); evt = 8'h00;
        rd_at(11, v); chk("R9 cmd event", v, 8'h93);
        @(negedge clk);
        wr = 1'b1; addr = 6'd11; wdata = 8'h00; evt = 8'h01;
        @(negedge clk);
        wr = 1'b0; evt = 8'h00;
        rd_at(11, v); chk("R9 event beats write", v, 8'h01);

        // R5 tick clears the sub-second byte
        wr_at(0, 8'h42);
        rd_at(0, v); chk("R5 frac written", v, 8'h42);
        tick_once();
        rd_at(0, v); chk("R5 frac cleared", v, 8'h00);

        // R3 long run of consecutive seconds
        load_time(50, 58, 0, 3, 15, 6, 30);
        for (int i = 0; i < 130; i++) begin
            tick_once();
            model_step();
            cmp_time("R3 run");
        end
        load_time(59, 59, 23, 2, 10, 3, 30);
        tick_once(); model_step(); cmp_time("R3 day wrap");

        // R4 month ends in leap and common years
        foreach (yrs[k]) begin
            for (int mo = 1; mo <= 12; mo++) begin
                load_time(59, 59, 23, 7, dim(mo, yrs[k]), mo, yrs[k]);
                tick_once(); model_step(); cmp_time("R4 month end");
            end
        end
        load_time(59, 59, 23, 1, 28, 2, 24);
        tick_once(); model_step(); cmp_time("R4 leap feb28");

        // R6 write visibility timing
        load_time(10, 20, 5, 1, 1, 1, 30);
        @(negedge clk);
        wr = 1'b1; addr = 6'd1; wdata = 8'h33;
        @(negedge clk);
        wr = 1'b0; rd = 1'b0; addr = 6'd1;
        #0.5 chk("R6 old before reload", int'(rdata), 8'h10);
        @(negedge clk);
        #0.5 chk("R6 new after reload", int'(rdata), 8'h33);
        ms = 33;
        tick_once(); model_step(); cmp_time("R6 counts on");

        // R7 write and tick in one cycle
        load_time(59, 10, 5, 1, 1, 1, 30);
        @(negedge clk);
        wr = 1'b1; addr = 6'd1; wdata = 8'h05; tick = 1'b1;
        @(negedge clk);
        wr = 1'b0; tick = 1'b0;
        @(negedge clk);
        rd_at(1, v); chk("R7 written sec", v, 8'h05);
        rd_at(2, v); chk("R7 min carried", v, 8'h11);

        // R8 reload held off by a read on the timekeeping area
        load_time(16, 10, 5, 1, 1, 1, 30);
        @(negedge clk);
        rd = 1'b1; addr = 6'd1; tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        for (int i = 0; i < 4; i++) begin
            #0.5 chk("R8 held during read", int'(rdata), 8'h16);
            @(negedge clk);
        end
        rd = 1'b0;
        @(negedge clk);
        rd_at(1, v); chk("R8 reload after read", v, 8'h17);
        // read on a storage byte does not hold off the reload
        @(negedge clk);
        rd = 1'b1; addr = 6'd32; tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        @(negedge clk);
        addr = 6'd1;
        #0.5 chk("R8 storage read no hold", int'(rdata), 8'h18);
        rd = 1'b0;

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule